// File: doc/BRIEF.md
# DMA Channel Style Router

This block sits between seven DMA channels and the three ways each one can be serviced. A 16-bit configuration word assigns every channel its own style, independently of the others. The styles are:

- a legacy request/acknowledge handshake on per-channel lines;
- service through one of three dedicated request/grant pairs;
- remote register service, which this block only flags on a per-channel select output.

Each channel takes exactly one style at a time.

For a channel in request/grant style, a pair raises its request and names a channel number. The router grants one pair and runs a two-phase transfer on a simple transaction port, which hands each phase back with a one-cycle done pulse. In peripheral-to-memory direction the first phase reads the peripheral and the second writes the captured byte to memory. In memory-to-peripheral direction the order is swapped. The memory side uses the channel's current address, which is loaded through a small write port and advances by one after each completed transfer.

Top module: `dma_style_router`

## Requirements
- R1: The configuration register resets to zero. A write stores bits [13:0]. Reading back always returns bits [15:14] as zero.
- R2: Channel n (0 to 6) is set by bits [2n+1:2n]: 00 legacy, 01 request/grant, 10 remote service, and 11 reserved, which behaves as legacy. `dist_sel[n]` is high exactly when the field is 10.
- R3: `dack[n]` is high in the cycle after `dreq[n]` was high, provided channel n was in legacy style (00 or 11) at that edge. A `dreq` on any other channel never raises its `dack`.
- R4: A pair's request is accepted only if the 3-bit channel number it presents is below 7 and that channel is in request/grant style. Otherwise it is ignored and no grant appears.
- R5: Among acceptable requests, the lowest pair index wins. `pg_gnt` is one-hot or zero, and it is held for the whole two-phase transfer.
- R6: With `ch_dir[n]`=0 (peripheral to memory), phase one is a peripheral read (`tx_mem`=0, `tx_write`=0). Phase two is a memory write (`tx_mem`=1, `tx_write`=1) whose `tx_wdata` is the `tx_rdata` captured with phase one's `tx_done`.
- R7: With `ch_dir[n]`=1 (memory to peripheral), phase one is a memory read and phase two a peripheral write.
- R8: During a transfer, `tx_addr` carries the channel's current address and `tx_chan` its number. The command stays stable until `tx_done`. When idle, all `tx_*` outputs and `pg_gnt` are zero.
- R9: An address write sets a channel's current address, and a channel number of 7 is ignored. On completion of phase two the channel's address increments by one, wrapping at 2^16.
- R10: From idle, the grant and phase one appear in the cycle after an acceptable request. The sequencer returns to idle in the cycle after phase two's `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| addr_we | input | 1 | Current-address write strobe |
| addr_ch | input | 3 | Channel whose address is written |
| addr_wdata | input | 16 | Address value to load |
| ch_dir | input | 7 | Per-channel direction, 1 = memory to peripheral |
| dreq | input | 7 | Legacy request lines |
| dack | output | 7 | Legacy acknowledge lines |
| dist_sel | output | 7 | Channels set to remote service |
| pg_req | input | 3 | Request from each pair |
| pg_chan | input | 9 | Channel number presented by each pair, 3 bits per pair |
| pg_gnt | output | 3 | Grant to each pair |
| tx_valid | output | 1 | Transaction phase active |
| tx_write | output | 1 | Phase is a write |
| tx_mem | output | 1 | Phase targets memory (else peripheral) |
| tx_chan | output | 3 | Channel of the transfer |
| tx_addr | output | 16 | Current address of the channel |
| tx_wdata | output | 8 | Data for the write phase |
| tx_rdata | input | 8 | Data returned by the read phase |
| tx_done | input | 1 | Phase complete pulse |

## Verification
The bench drives the reserved encoding 11 and checks it acknowledges like legacy; a decoder that treated it as remote or as request/grant would leave `dack` low. It presents pairs naming a remote-style channel and the nonexistent channel 7, which a careless decoder would grant. It raises two acceptable pairs at once, so a wrong priority or a grant that moves mid-transfer shows up in `pg_gnt`. It runs both directions and checks that the second phase writes the byte read in the first. It lets an address of FFFF wrap to 0000, which an increment that saturated or skipped would get wrong.

// File: rtl/dma_style_router.sv
module dma_style_router #(
  parameter int NCH   = 7,
  parameter int NPAIR = 3,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CFGW  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFGW-1:0]                  cfg_wdata,
  output logic [CFGW-1:0]                  cfg_rdata,
  input  logic                             addr_we,
  input  logic [$clog2(NCH+1)-1:0]         addr_ch,
  input  logic [AW-1:0]                    addr_wdata,
  input  logic [NCH-1:0]                   ch_dir,
  input  logic [NCH-1:0]                   dreq,
  output logic [NCH-1:0]                   dack,
  output logic [NCH-1:0]                   dist_sel,
  input  logic [NPAIR-1:0]                 pg_req,
  input  logic [NPAIR*$clog2(NCH+1)-1:0]   pg_chan,
  output logic [NPAIR-1:0]                 pg_gnt,
  output logic                             tx_valid,
  output logic                             tx_write,
  output logic                             tx_mem,
  output logic [$clog2(NCH+1)-1:0]         tx_chan,
  output logic [AW-1:0]                    tx_addr,
  output logic [DW-1:0]                    tx_wdata,
  input  logic [DW-1:0]                    tx_rdata,
  input  logic                             tx_done
);
  localparam int CHW  = $clog2(NCH + 1);
  localparam int FW   = 2 * NCH;
  localparam int PW   = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam int NPAD = 2 ** CHW;

  typedef enum logic [1:0] {IDLE, PH1, PH2} ph_t;

  logic [FW-1:0]   cfg_q;
  logic [NCH-1:0]  is_leg, is_rg;
  logic [NPAD-1:0] rg_pad, dir_pad;
  logic [NPAIR-1:0] elig;
  logic [PW-1:0]   pick;
  logic            pick_any;
  logic [CHW-1:0]  pick_chan;

  ph_t             ph;
  logic [PW-1:0]   own;
  logic [CHW-1:0]  ch;
  logic            dir;
  logic [AW-1:0]   cur;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   addr_mem [NCH];
  logic            busy;

  assign cfg_rdata = CFGW'(cfg_q);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [1:0] f;
    assign f           = cfg_q[2*n +: 2];
    assign is_leg[n]   = (f == 2'b00) || (f == 2'b11);
    assign is_rg[n]    = (f == 2'b01);
    assign dist_sel[n] = (f == 2'b10);
  end

  assign rg_pad  = {{(NPAD-NCH){1'b0}}, is_rg};
  assign dir_pad = {{(NPAD-NCH){1'b0}}, ch_dir};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign elig[p] = pg_req[p] && rg_pad[pg_chan[p*CHW +: CHW]];
  end

  always_comb begin
    pick     = '0;
    pick_any = 1'b0;
    for (int p = NPAIR - 1; p >= 0; p--)
      if (elig[p]) begin
        pick     = PW'(p);
        pick_any = 1'b1;
      end
  end
  assign pick_chan = pg_chan[pick*CHW +: CHW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dack  <= '0;
    end else begin
      dack <= dreq & is_leg;
      if (cfg_we) cfg_q <= cfg_wdata[FW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= IDLE;
      own    <= '0;
      ch     <= '0;
      dir    <= 1'b0;
      cur    <= '0;
      data_q <= '0;
      for (int n = 0; n < NCH; n++) addr_mem[n] <= '0;
    end else begin
      case (ph)
        IDLE: if (pick_any) begin
          ph  <= PH1;
          own <= pick;
          ch  <= pick_chan;
          dir <= dir_pad[pick_chan];
          cur <= addr_mem[pick_chan];
        end
        PH1: if (tx_done) begin
          data_q <= tx_rdata;
          ph     <= PH2;
        end
        PH2: if (tx_done) ph <= IDLE;
        default: ph <= IDLE;
      endcase
      for (int n = 0; n < NCH; n++) begin
        if (addr_we && int'(addr_ch) == n)
          addr_mem[n] <= addr_wdata;
        else if (ph == PH2 && tx_done && int'(ch) == n)
          addr_mem[n] <= cur + AW'(1);
      end
    end
  end

  assign busy     = (ph != IDLE);
  assign pg_gnt   = busy ? (NPAIR'(1) << own) : '0;
  assign tx_valid = busy;
  assign tx_write = (ph == PH2);
  assign tx_mem   = (ph == PH1) ? dir : (ph == PH2) ? ~dir : 1'b0;
  assign tx_chan  = busy ? ch : '0;
  assign tx_addr  = busy ? cur : '0;
  assign tx_wdata = (ph == PH2) ? data_q : '0;

  a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pg_gnt));

  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_done |=> tx_valid && $stable(tx_addr) && $stable(tx_chan)
                             && $stable(tx_write) && $stable(tx_mem) && $stable(pg_gnt));

  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_write) |-> $past(tx_done) && $past(tx_valid));

  a_r4_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(|pg_req));

  a_r3_dack_follows_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    (dack & ~$past(dreq)) == '0);

  a_r10_idle_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write && tx_done |=> !tx_valid);
endmodule

// File: tb/dma_style_router_test.sv
module dma_style_router_test;
  localparam int NCH = 7, NPAIR = 3, AW = 16, DW = 8, CFGW = 16, CHW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst_n = 1'b0;
  logic                   cfg_we = 1'b0;
  logic [CFGW-1:0]        cfg_wdata = '0;
  logic [CFGW-1:0]        cfg_rdata;
  logic                   addr_we = 1'b0;
  logic [CHW-1:0]         addr_ch = '0;
  logic [AW-1:0]          addr_wdata = '0;
  logic [NCH-1:0]         ch_dir = '0;
  logic [NCH-1:0]         dreq = '0;
  logic [NCH-1:0]         dack;
  logic [NCH-1:0]         dist_sel;
  logic [NPAIR-1:0]       pg_req = '0;
  logic [NPAIR*CHW-1:0]   pg_chan = '0;
  logic [NPAIR-1:0]       pg_gnt;
  logic                   tx_valid, tx_write, tx_mem;
  logic [CHW-1:0]         tx_chan;
  logic [AW-1:0]          tx_addr;
  logic [DW-1:0]          tx_wdata;
  logic [DW-1:0]          tx_rdata = '0;
  logic                   tx_done = 1'b0;

  dma_style_router uut (.*);

  int checks = 0, errors = 0, cyc = 0, wcnt = 0, txn = 0;

  logic [13:0]    m_cfg;
  logic [AW-1:0]  m_addr [NCH];
  bit             m_busy;
  int             m_phase, m_pair, m_ch;
  bit             m_dir;
  logic [AW-1:0]  m_cur;
  logic [DW-1:0]  m_data;
  logic [NCH-1:0] m_dack;

  function automatic int style(int n);
    return int'((m_cfg >> (2 * n)) & 14'd3);
  endfunction

  function automatic bit legacy(int n);
    int s = style(n);
    return (s == 0) || (s == 3);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_tick();
    logic [NCH-1:0] nd;
    if (!rst_n) begin
      m_cfg = '0; m_busy = 0; m_phase = 0; m_pair = 0; m_ch = 0;
      m_dir = 0; m_cur = '0; m_data = '0; m_dack = '0;
      for (int n = 0; n < NCH; n++) m_addr[n] = '0;
    end else begin
      for (int n = 0; n < NCH; n++) nd[n] = dreq[n] && legacy(n);
      if (m_busy) begin
        if (tx_done) begin
          if (m_phase == 1) begin
            m_data = tx_rdata; m_phase = 2;
          end else begin
            m_busy = 0; m_phase = 0; m_addr[m_ch] = m_cur + 16'd1;
          end
        end
      end else begin
        for (int p = 0; p < NPAIR; p++) begin
          int c = int'(pg_chan[p*CHW +: CHW]);
          if (pg_req[p] && c < NCH && style(c) == 1) begin
            m_busy = 1; m_phase = 1; m_pair = p; m_ch = c;
            m_dir = ch_dir[c]; m_cur = m_addr[c];
            break;
          end
        end
      end
      m_dack = nd;
      if (addr_we && int'(addr_ch) < NCH) m_addr[addr_ch] = addr_wdata;
      if (cfg_we) m_cfg = cfg_wdata[13:0];
    end
  endtask

  task automatic compare_all();
    logic [NCH-1:0] e;
    for (int n = 0; n < NCH; n++) e[n] = (style(n) == 2);
    chk("R1", "cfg_rdata", cfg_rdata, {18'b0, m_cfg});
    chk("R2", "dist_sel", dist_sel, e);
    chk("R3", "dack", dack, m_dack);
    chk("R4 R5 R10", "pg_gnt", pg_gnt, m_busy ? (1 << m_pair) : 0);
    chk("R10", "tx_valid", tx_valid, m_busy);
    chk("R6 R7", "tx_write", tx_write, m_phase == 2);
    chk("R6 R7", "tx_mem", tx_mem, m_busy ? ((m_phase == 1) ? m_dir : !m_dir) : 0);
    chk("R8", "tx_chan", tx_chan, m_busy ? m_ch : 0);
    chk("R8 R9", "tx_addr", tx_addr, m_busy ? m_cur : 0);
    chk("R6", "tx_wdata", tx_wdata, (m_phase == 2) ? m_data : 0);
  endtask

  task automatic respond();
    if (tx_done) tx_done = 1'b0;
    else if (tx_valid) begin
      if (wcnt == 0) begin
        tx_done  = 1'b1;
        tx_rdata = DW'(8'h5A + txn * 7);
        txn++;
        wcnt = txn % 3;
      end else wcnt--;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    cyc++;
    compare_all();
    respond();
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_grant();
    for (int k = 0; k < 50 && pg_gnt == 0; k++) step();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 50 && tx_valid; k++) step();
  endtask

  task automatic set_addr(int c, logic [AW-1:0] v);
    addr_we = 1'b1; addr_ch = CHW'(c); addr_wdata = v;
    step();
    addr_we = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    chk("R1", "reset config", cfg_rdata, 0);
    chk("R3", "reset dack", dack, 0);
    rst_n = 1'b1;
    step();

    cfg_we = 1'b1; cfg_wdata = 16'hFFFF; step(); cfg_we = 1'b0; step();
    chk("R1", "top bits read zero", cfg_rdata, 32'h3FFF);
    dreq = 7'h7F; step(); step();
    chk("R2 R3", "reserved acts as legacy", dack, 32'h7F);
    dreq = '0;
    pg_chan = {3'd3, 3'd2, 3'd1}; pg_req = 3'b111;
    repeat (3) step();
    chk("R4", "no grant for legacy channels", pg_gnt, 0);
    pg_req = '0;

    cfg_we = 1'b1; cfg_wdata = 16'hE764; step(); cfg_we = 1'b0; step();
    chk("R1", "mixed config readback", cfg_rdata, 32'h2764);
    chk("R2", "remote channels 2 and 6", dist_sel, 32'h44);
    dreq = 7'h7F; step(); step();
    chk("R3", "only legacy channels acknowledged", dack, 32'h11);
    dreq = 7'b1010101; step(); step();
    chk("R3", "second request pattern", dack, 32'h11);
    dreq = '0;

    set_addr(1, 16'h0100);
    set_addr(3, 16'h0FFF);
    set_addr(5, 16'hFFFF);
    set_addr(7, 16'h1234);
    ch_dir = 7'b0001000;

    pg_chan = {3'd7, 3'd2, 3'd1}; pg_req = 3'b001;
    step();
    chk("R10", "grant one cycle after request", pg_gnt, 32'h1);
    chk("R6", "phase one reads peripheral", {tx_write, tx_mem}, 0);
    chk("R8", "address of channel 1", tx_addr, 32'h0100);
    pg_req = 3'b110;
    wait_idle();
    repeat (3) step();
    chk("R4", "remote and invalid channel ignored", pg_gnt, 0);
    pg_req = 3'b001; step();
    chk("R9", "address advanced", tx_addr, 32'h0101);
    pg_req = '0;
    wait_idle();

    pg_chan = {3'd5, 3'd3, 3'd0}; pg_req = 3'b110;
    step();
    chk("R5", "lowest pair wins", pg_gnt, 32'h2);
    chk("R7", "phase one reads memory", {tx_write, tx_mem}, 32'h1);
    pg_req = 3'b100;
    wait_idle();
    wait_grant();
    chk("R5", "waiting pair served next", pg_gnt, 32'h4);
    chk("R8", "address of channel 5", tx_addr, 32'hFFFF);
    wait_idle();
    wait_grant();
    chk("R9", "address wraps", tx_addr, 32'h0000);
    pg_req = '0;
    wait_idle();
    repeat (4) step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule